// File: doc/BRIEF.md
# Foreground LMS Weight Calibrator for a Sub-Radix-2 SAR Converter

This block is the digital back end of a successive-approximation converter whose capacitor array uses a radix below two. Because the real bit weights deviate from their design values, the block learns them on chip before it produces any output. A calibration run starts with a pulse. During the run the analog side converts each sample of a slow differential ramp twice. One conversion carries a small positive offset and the other carries a small negative offset of the same known size. The block receives the raw decision bits of both conversions as one pair. It then adjusts one weight per raw bit with a least-mean-square step, so that the difference between the two weighted results moves toward twice the offset.

The run ends after a programmed number of pairs, and the weights are then frozen. In normal mode each raw conversion becomes a 12-bit code. The code is the rounded sum of the set bits' weights, clamped to the code range. Weights are fixed point with 8 fractional bits below one output LSB. The step size is a power of two, so each update is a shift and an add.

Top module: `sar_lms_cal`

## Requirements
- R1: After reset, cal_busy, cal_done and code_valid are 0, and the block stays idle until a start pulse.
- R2: Nominal weights, in units of 2^-8 output LSB, are computed as follows. FS = (4096+256)*256. The top bit's weight is w[13] = floor(FS*(Q-128)/Q). Each lower weight is w[i] = floor(w[i+1]*128/Q). Q is the radix in Q7 format, with default 236.
- R3: cal_start has priority in any state, and any raw_valid in the same cycle is ignored. One cycle after the pulse, cal_busy is 1, every weight holds its nominal value, and cal_iters is captured as the pair count.
- R4: Each raw_valid during calibration applies one update. The error is e = S(raw_a) - S(raw_b) - 2*16*256, where S is the weighted sum. The step is s = floor(e/64). A weight whose bit is 1 in raw_a and 0 in raw_b loses s. A weight whose bit is 0 in raw_a and 1 in raw_b gains s. All other weights keep their values.
- R5: After cal_iters pairs have been accepted, cal_busy falls and cal_done rises within two cycles. With cal_iters = 0, calibration finishes without any update. Cycles without raw_valid do not consume the count.
- R6: code_valid stays 0 while the block is idle or calibrating.
- R7: With cal_done set, raw_valid yields code_valid = 1 one cycle later. The code is floor((S(raw_a)+128)/256). raw_b is ignored in this mode.
- R8: The output saturates to 0 when the rounded sum is negative and to 4095 when it exceeds 4095.
- R9: Weights do not change in normal mode, so the same raw input always gives the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Pulse: reload nominal weights and begin calibration |
| cal_iters | input | 16 | Number of perturbed pairs in the calibration run |
| raw_valid | input | 1 | Raw conversion (pair) present this cycle |
| raw_a | input | 14 | Raw bits: +offset conversion, or the normal conversion |
| raw_b | input | 14 | Raw bits of the -offset conversion (calibration only) |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Weights frozen, normal mode active |
| code_valid | output | 1 | Output code strobe |
| code | output | 12 | Calibrated, rounded, saturated output code |

## Verification
The update rule is exercised with eight ramp-like pairs whose raw_a and raw_b differ in several low and middle bits, so both the gain and the loss branch of the step fire on many weights. Normal codes taken across the whole raw range then show whether every learned weight and the rounding are right. A repeated single-bit pair drives one weight negative, which separates clamping to 0 from ordinary rounding. With zero iterations, the all-ones input separates clamping to 4095 from a wrong nominal weight set. A start pulse that arrives together with a pair, and a restart in the middle of a run, show that reload has priority over an update.

// File: rtl/sar_cal_pkg.sv
package sar_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAL  = 2'd1,
        ST_RUN  = 2'd2
    } cal_state_e;

    // Nominal sub-radix-2 weight of raw bit idx, in 2^-frac output LSB.
    function automatic longint nom_weight(input int idx, input int nbits,
                                          input int out_w, input int frac,
                                          input int rq);
        longint w;
        w = ((longint'(1) << out_w) + (longint'(1) << (out_w - 4))) << frac;
        w = (w * (rq - 128)) / rq;
        for (int k = nbits - 1; k > idx; k--) begin
            w = (w * 128) / rq;
        end
        return w;
    endfunction

endpackage

// File: rtl/sar_wsum.sv
module sar_wsum #(
    parameter int NBITS = 14,
    parameter int WW    = 24,
    parameter int SW    = 28
) (
    input  logic [NBITS-1:0]         bits_i,
    input  logic [NBITS-1:0][WW-1:0] w_i,
    output logic signed [SW-1:0]     sum_o
);
    logic signed [SW-1:0] term [NBITS];

    for (genvar g = 0; g < NBITS; g++) begin : g_term
        assign term[g] = bits_i[g] ? $signed({{(SW-WW){w_i[g][WW-1]}}, w_i[g]})
                                   : '0;
    end

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NBITS; i++) begin
            sum_o = sum_o + term[i];
        end
    end
endmodule

// File: rtl/sar_code_fmt.sv
module sar_code_fmt #(
    parameter int SW    = 28,
    parameter int OUT_W = 12,
    parameter int FRAC  = 8
) (
    input  logic signed [SW-1:0] sum_i,
    output logic [OUT_W-1:0]     code_o
);
    localparam logic signed [SW:0] HALF = (SW+1)'(1) <<< (FRAC - 1);
    localparam logic signed [SW:0] TOP  = (SW+1)'((1 << OUT_W) - 1);

    logic signed [SW:0] rnd;
    logic signed [SW:0] q;

    always_comb begin
        rnd = $signed({sum_i[SW-1], sum_i}) + HALF;
        q   = rnd >>> FRAC;
        if (q < 0) begin
            code_o = '0;
        end else if (q > TOP) begin
            code_o = '1;
        end else begin
            code_o = q[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/sar_lms_cal.sv
module sar_lms_cal #(
    parameter int NBITS     = 14,
    parameter int OUT_W     = 12,
    parameter int FRAC      = 8,
    parameter int WW        = 24,
    parameter int ITER_W    = 16,
    parameter int MU_SHIFT  = 6,
    parameter int DELTA_LSB = 16,
    parameter int RADIX_Q7  = 236
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic [ITER_W-1:0] cal_iters,
    input  logic              raw_valid,
    input  logic [NBITS-1:0]  raw_a,
    input  logic [NBITS-1:0]  raw_b,
    output logic              cal_busy,
    output logic              cal_done,
    output logic              code_valid,
    output logic [OUT_W-1:0]  code
);
    import sar_cal_pkg::*;

    localparam int SW = WW + $clog2(NBITS);
    localparam logic signed [SW:0] TWO_DELTA = (SW+1)'(2 * DELTA_LSB * (2 ** FRAC));

    typedef struct packed {
        cal_state_e               state;
        logic [ITER_W-1:0]        iter;
        logic [NBITS-1:0][WW-1:0] w;
        logic                     code_vld;
        logic [OUT_W-1:0]         code;
    } regs_t;

    regs_t r_q, r_d, rst_v;

    logic [NBITS-1:0][WW-1:0] nom_w;
    logic signed [SW-1:0]     sum_a, sum_b;
    logic signed [SW:0]       err, step;
    logic [OUT_W-1:0]         code_nx;

    for (genvar g = 0; g < NBITS; g++) begin : g_nom
        localparam logic [WW-1:0] NV =
            WW'(nom_weight(g, NBITS, OUT_W, FRAC, RADIX_Q7));
        assign nom_w[g] = NV;
    end

    sar_wsum #(.NBITS(NBITS), .WW(WW), .SW(SW)) u_sum_a (
        .bits_i(raw_a), .w_i(r_q.w), .sum_o(sum_a));
    sar_wsum #(.NBITS(NBITS), .WW(WW), .SW(SW)) u_sum_b (
        .bits_i(raw_b), .w_i(r_q.w), .sum_o(sum_b));
    sar_code_fmt #(.SW(SW), .OUT_W(OUT_W), .FRAC(FRAC)) u_fmt (
        .sum_i(sum_a), .code_o(code_nx));

    function automatic logic [WW-1:0] adj(input logic [WW-1:0] w,
                                          input logic signed [SW:0] s,
                                          input logic up);
        logic signed [SW:0] wx;
        wx = $signed({{(SW+1-WW){w[WW-1]}}, w});
        wx = up ? (wx + s) : (wx - s);
        return wx[WW-1:0];
    endfunction

    assign err  = $signed({sum_a[SW-1], sum_a}) - $signed({sum_b[SW-1], sum_b}) - TWO_DELTA;
    assign step = err >>> MU_SHIFT;

    always_comb begin
        rst_v          = '0;
        rst_v.state    = ST_IDLE;
        rst_v.w        = nom_w;

        r_d            = r_q;
        r_d.code_vld   = 1'b0;
        if (cal_start) begin
            r_d.state = ST_CAL;
            r_d.iter  = cal_iters;
            r_d.w     = nom_w;
        end else begin
            unique case (r_q.state)
                ST_CAL: begin
                    if (r_q.iter == '0) begin
                        r_d.state = ST_RUN;
                    end else if (raw_valid) begin
                        r_d.iter = r_q.iter - 1'b1;
                        for (int i = 0; i < NBITS; i++) begin
                            if (raw_a[i] && !raw_b[i]) begin
                                r_d.w[i] = adj(r_q.w[i], step, 1'b0);
                            end else if (!raw_a[i] && raw_b[i]) begin
                                r_d.w[i] = adj(r_q.w[i], step, 1'b1);
                            end
                        end
                    end
                end
                ST_RUN: begin
                    if (raw_valid) begin
                        r_d.code_vld = 1'b1;
                        r_d.code     = code_nx;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= rst_v;
        end else begin
            r_q <= r_d;
        end
    end

    assign cal_busy   = (r_q.state == ST_CAL);
    assign cal_done   = (r_q.state == ST_RUN);
    assign code_valid = r_q.code_vld;
    assign code       = r_q.code;

    // R3
    start_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> (cal_busy && r_q.w == nom_w));
    // R6
    no_early_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(r_q.state == ST_RUN));
    // R9
    weight_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_CAL && !cal_start) |=> $stable(r_q.w));
    // R5
    iter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CAL && !raw_valid && !cal_start) |=> $stable(r_q.iter));
    // R8
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && raw_valid && !cal_start && sum_a < 0) |=> (code == '0));
endmodule

// File: tb/sar_lms_cal_tb.sv
module sar_lms_cal_tb_top;
    localparam int NB = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_start = 1'b0;
    logic [15:0]   cal_iters = '0;
    logic          raw_valid = 1'b0;
    logic [NB-1:0] raw_a = '0;
    logic [NB-1:0] raw_b = '0;
    logic          cal_busy, cal_done, code_valid;
    logic [11:0]   code;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sar_lms_cal #(.NBITS(NB), .OUT_W(12), .FRAC(8), .WW(24), .ITER_W(16),
                  .MU_SHIFT(6), .DELTA_LSB(16), .RADIX_Q7(236)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_iters(cal_iters),
        .raw_valid(raw_valid), .raw_a(raw_a), .raw_b(raw_b),
        .cal_busy(cal_busy), .cal_done(cal_done), .code_valid(code_valid),
        .code(code));

    localparam logic [27:0] CAL_VEC [8] = '{
        {14'h0A52, 14'h0A31}, {14'h1204, 14'h11E9}, {14'h1A80, 14'h1A66},
        {14'h2211, 14'h21F0}, {14'h2990, 14'h2974}, {14'h3105, 14'h30E8},
        {14'h3822, 14'h3808}, {14'h05A1, 14'h0588}};
    localparam logic [NB-1:0] RUN_VEC [6] = '{
        14'h0000, 14'h0001, 14'h0A52, 14'h2000, 14'h1F3C, 14'h3FFF};

    // Reference model of the requirements
    longint mw [NB];

    function automatic void m_nominal();
        longint w;
        w = (longint'(4096 + 256) * 256 * (236 - 128)) / 236;
        for (int i = NB - 1; i >= 0; i--) begin
            mw[i] = w;
            w = (w * 128) / 236;
        end
    endfunction

    function automatic longint m_sum(input logic [NB-1:0] a);
        longint s = 0;
        for (int i = 0; i < NB; i++) if (a[i]) s += mw[i];
        return s;
    endfunction

    function automatic void m_update(input logic [NB-1:0] a, input logic [NB-1:0] b);
        longint e, st;
        e  = m_sum(a) - m_sum(b) - 2 * 16 * 256;
        st = e >>> 6;
        for (int i = 0; i < NB; i++) begin
            if (a[i] && !b[i]) mw[i] -= st;
            else if (!a[i] && b[i]) mw[i] += st;
        end
    endfunction

    function automatic longint m_code(input logic [NB-1:0] a);
        longint q = (m_sum(a) + 128) >>> 8;
        if (q < 0) return 0;
        if (q > 4095) return 4095;
        return q;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_cal(input logic [15:0] n, input bit with_pair);
        @(negedge clk);
        cal_start = 1'b1;
        cal_iters = n;
        raw_valid = with_pair;
        raw_a = 14'h3FFF;
        raw_b = 14'h0000;
        @(negedge clk);
        cal_start = 1'b0;
        raw_valid = 1'b0;
        m_nominal();
    endtask

    task automatic pair(input logic [NB-1:0] a, input logic [NB-1:0] b);
        @(negedge clk);
        raw_valid = 1'b1; raw_a = a; raw_b = b;
        @(negedge clk);
        raw_valid = 1'b0;
        m_update(a, b);
    endtask

    task automatic conv(input logic [NB-1:0] a, input string req);
        longint exp;
        exp = m_code(a);
        @(negedge clk);
        raw_valid = 1'b1; raw_a = a; raw_b = ~a;
        @(negedge clk);
        raw_valid = 1'b0;
        chk(code_valid == 1'b1, req, code_valid, 1);
        chk(code == exp, req, code, exp);
    endtask

    initial begin
        longint first_code;
        m_nominal();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cal_busy, "R1 busy", cal_busy, 0);
        chk(!cal_done, "R1 done", cal_done, 0);
        chk(!code_valid, "R1 valid", code_valid, 0);

        // R6 idle ignores conversions
        @(negedge clk); raw_valid = 1'b1; raw_a = 14'h1234;
        @(negedge clk); raw_valid = 1'b0;
        chk(!code_valid, "R6 idle", code_valid, 0);

        // R3 start, R4 LMS walk over table
        start_cal(16'd8, 1'b0);
        chk(cal_busy, "R3 busy after start", cal_busy, 1);
        foreach (CAL_VEC[k]) begin
            pair(CAL_VEC[k][27:14], CAL_VEC[k][13:0]);
            chk(!code_valid, "R6 cal", code_valid, 0);
        end
        repeat (2) @(negedge clk);
        chk(cal_done && !cal_busy, "R5 done after count", cal_done, 1);

        // R7 normal conversion with learned weights (R4)
        foreach (RUN_VEC[k]) conv(RUN_VEC[k], "R7/R4 code");
        first_code = m_code(RUN_VEC[2]);
        // R9 freeze: repeat input after many conversions
        repeat (4) conv(14'h2ABC, "R9 run");
        conv(RUN_VEC[2], "R9 repeat");
        chk(code == first_code, "R9 same code", code, first_code);

        // R3 restart mid-run, then start with a concurrent pair, zero count
        start_cal(16'd5, 1'b0);
        pair(14'h0F0F, 14'h0F00);
        chk(cal_busy && !cal_done, "R5 count not reached", cal_busy, 1);
        repeat (3) @(negedge clk);
        chk(cal_busy, "R5 idle cycles keep count", cal_busy, 1);
        start_cal(16'd0, 1'b1);
        @(negedge clk);
        chk(cal_done, "R5 zero iterations", cal_done, 1);
        // R2 nominal weights visible
        conv(14'h1F3C, "R2 nominal");
        conv(14'h0001, "R2 nominal lsb");
        // R8 high saturation
        conv(14'h3FFF, "R8 high");
        chk(code == 12'd4095, "R8 high literal", code, 4095);

        // R8 low saturation: drive bit0 weight negative
        start_cal(16'd6, 1'b0);
        repeat (6) pair(14'h0000, 14'h0001);
        repeat (2) @(negedge clk);
        chk(cal_done, "R5 done", cal_done, 1);
        conv(14'h0001, "R8 low");
        chk(code == 12'd0, "R8 low literal", code, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule